// File: doc/BRIEF.md
# Conversion Event Interrupt Status Unit

This block gathers the event pulses produced around one digital filter that serves four input channels and turns them into sticky status flags and one interrupt request line. It keeps two conversion groups, a regular group and an injected group. For each group it holds the latest result word, a conversion-complete flag and an overrun flag. For each channel it holds high-threshold and low-threshold watchdog hits, short-circuit detections and clock-absence detections.

Software reaches the block through a small register port. Reads are combinational and writes take effect at the clock edge. A conversion-complete flag clears when software reads that group's result register. Every other flag clears only when software writes a one to its bit in a clear register. A per-source enable register masks the flags into a registered interrupt output. The filter, the threshold comparators and the detectors sit outside this block, and only their single-cycle pulses enter it.

Register map (word address on `bus_addr`): 0 status, 1 enable, 2 flag clear, 3 watchdog status, 4 watchdog clear, 5 injected result, 6 regular result. Status bits: 0 injected complete, 1 regular complete, 2 injected overrun, 3 regular overrun, 4 watchdog summary, 11:8 short-circuit per channel, 19:16 clock absence per channel. Enable bits: 0 injected complete, 1 regular complete, 2 injected overrun, 3 regular overrun, 4 watchdog, 5 short-circuit (any channel), 6 clock absence (any channel). Watchdog status and watchdog clear: bits 3:0 high hits and bits 11:8 low hits, one bit per channel. The flag clear register uses the same bit positions as status for bits 2, 3, 11:8 and 19:16.

Top module: `cevt_irq_unit`

## Requirements
- R1: A `*_done` pulse stores its data word in the group's result register (address 5 injected, 6 regular) and sets the group's complete flag (status bit 0 injected, bit 1 regular).
- R2: A read of a group's result register clears that group's complete flag at the clock edge of the read, and the read returns the stored word.
- R3: A `*_done` pulse that arrives while the group's complete flag is set, in a cycle with no read of that group's result, sets the group's overrun flag (status bit 2 injected, bit 3 regular). A pulse that arrives after the result was read sets no overrun.
- R4: An overrun flag is cleared only by a write with a one at its bit (2 or 3) to the clear register at address 2. A write of zero leaves it set.
- R5: When a result read and a new `*_done` pulse of the same group fall in one cycle, the read returns the old word, the complete flag stays set, no overrun is flagged, and the result register then holds the new word.
- R6: Watchdog high and low hits are recorded per channel at address 3 (high at bits 3:0, low at bits 11:8). Each bit is cleared by a one at the same bit of address 4.
- R7: Status bit 4 is one exactly while any per-channel watchdog high or low bit is set.
- R8: A short-circuit pulse sets status bit 8+n only when `sc_det_en[n]` is high, and is otherwise ignored. Each bit is cleared by a one at the same bit of address 2.
- R9: A clock-absence pulse sets status bit 16+n only when `ck_det_en[n]` is high, and is otherwise ignored. Each bit is cleared by a one at the same bit of address 2.
- R10: If a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is a register holding the OR of all enabled sources. It changes one cycle after the flag or enable change that causes it, and a set flag whose enable is zero does not raise it.
- R12: After reset, all flags, the enable register, the result registers and `irq` read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; on a result address it clears the complete flag |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| inj_done | input | 1 | Injected conversion finished, one-cycle pulse |
| inj_data | input | 24 | Injected conversion result |
| reg_done | input | 1 | Regular conversion finished, one-cycle pulse |
| reg_data | input | 24 | Regular conversion result |
| wd_hi_evt | input | 4 | Per-channel high-threshold hit pulses |
| wd_lo_evt | input | 4 | Per-channel low-threshold hit pulses |
| sc_evt | input | 4 | Per-channel short-circuit pulses |
| sc_det_en | input | 4 | Per-channel short-circuit detection enable |
| ck_evt | input | 4 | Per-channel clock-absence pulses |
| ck_det_en | input | 4 | Per-channel clock-absence detection enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that every event input is a clean single-cycle pulse sampled at the clock edge. The stimulus drives all inputs on the falling edge and lowers each pulse after one cycle. It uses the bus for either a read or a write in any cycle, never both. Same-cycle collisions between a pulse and a read or a clear write are placed on purpose, because these collisions are the cases the priority rules cover.

// File: rtl/cevt_pkg.sv
package cevt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned N_SRC  = 7;

  // status register field positions
  localparam int unsigned ST_INJ_EOC = 0;
  localparam int unsigned ST_REG_EOC = 1;
  localparam int unsigned ST_INJ_OVR = 2;
  localparam int unsigned ST_REG_OVR = 3;
  localparam int unsigned ST_WD_SUM  = 4;
  localparam int unsigned ST_SC_LSB  = 8;
  localparam int unsigned ST_CK_LSB  = 16;
  // watchdog status field positions
  localparam int unsigned WD_HI_LSB  = 0;
  localparam int unsigned WD_LO_LSB  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_ENABLE = 3'd1,
    A_CLEAR  = 3'd2,
    A_WDSTAT = 3'd3,
    A_WDCLR  = 3'd4,
    A_INJRES = 3'd5,
    A_REGRES = 3'd6
  } addr_e;

  // interrupt sources, bit order equals the enable register layout
  typedef struct packed {
    logic ck;
    logic sc;
    logic wd;
    logic reg_ovr;
    logic inj_ovr;
    logic reg_eoc;
    logic inj_eoc;
  } src_t;
endpackage

// File: rtl/cevt_grp_flags.sv
module cevt_grp_flags #(
  parameter int unsigned RES_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] data,
  input  logic             rd_clr,
  input  logic             ovr_clr,
  output logic             eoc,
  output logic             ovr,
  output logic [RES_W-1:0] result
);
  logic             eoc_q, eoc_d;
  logic             ovr_q, ovr_d;
  logic             ovr_set;
  logic [RES_W-1:0] res_q;

  always_comb begin
    ovr_set = done & eoc_q & ~rd_clr;
    eoc_d   = done | (eoc_q & ~rd_clr);
    ovr_d   = ovr_set | (ovr_q & ~ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      eoc_q <= eoc_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (done) begin
      res_q <= data;
    end
  end

  assign eoc    = eoc_q;
  assign ovr    = ovr_q;
  assign result = res_q;

  assert_ovr_on_unread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && eoc && !rd_clr) |=> ovr);
  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
  assert_eoc_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !done) |=> !eoc);
  assert_eoc_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_clr) |=> eoc);
  assert_no_ovr_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_clr && !ovr) |=> !ovr);
endmodule

// File: rtl/cevt_chan_flags.sv
module cevt_chan_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] det_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] evt_g;
  logic [N-1:0] flg_q, flg_d;

  assign evt_g = evt & det_en;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_comb begin
      flg_d[i] = evt_g[i] | (flg_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q[i] <= 1'b0;
      end else begin
        flg_q[i] <= flg_d[i];
      end
    end

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_g[i] |=> flg_q[i]);
    // gating of disabled channels, serves R8 and R9
    assert_no_stray_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(evt[i] && det_en[i]) && !flg_q[i]) |=> !flg_q[i]);
  end

  assign flags = flg_q;
endmodule

// File: rtl/cevt_irq_out.sv
module cevt_irq_out #(
  parameter int unsigned NS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src,
  input  logic [NS-1:0] en,
  output logic          irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(src & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  assert_irq_quiet_without_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |=> !irq_q);
endmodule

// File: rtl/cevt_irq_unit.sv
module cevt_irq_unit
  import cevt_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned RES_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [BUS_W-1:0]          bus_wdata,
  input  logic                      bus_rd,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic                      inj_done,
  input  logic [RES_W-1:0]          inj_data,
  input  logic                      reg_done,
  input  logic [RES_W-1:0]          reg_data,
  input  logic [NCH-1:0]            wd_hi_evt,
  input  logic [NCH-1:0]            wd_lo_evt,
  input  logic [NCH-1:0]            sc_evt,
  input  logic [NCH-1:0]            sc_det_en,
  input  logic [NCH-1:0]            ck_evt,
  input  logic [NCH-1:0]            ck_det_en,
  output logic                      irq
);
  localparam logic [NCH-1:0] ALL_ON = '1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  // address decode
  addr_e a;
  logic  wr_en_reg, wr_clear, wr_wdclr, rd_inj, rd_reg;

  always_comb begin
    a         = addr_e'(bus_addr);
    wr_en_reg = bus_wr && (a == A_ENABLE);
    wr_clear  = bus_wr && (a == A_CLEAR);
    wr_wdclr  = bus_wr && (a == A_WDCLR);
    rd_inj    = bus_rd && (a == A_INJRES);
    rd_reg    = bus_rd && (a == A_REGRES);
  end

  // enable register
  logic [N_SRC-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en_reg) en_d = bus_wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  // clear vectors
  logic           clr_inj_ovr, clr_reg_ovr;
  logic [NCH-1:0] clr_sc, clr_ck, clr_hi, clr_lo;

  always_comb begin
    clr_inj_ovr = wr_clear & bus_wdata[ST_INJ_OVR];
    clr_reg_ovr = wr_clear & bus_wdata[ST_REG_OVR];
    clr_sc      = {NCH{wr_clear}} & bus_wdata[ST_SC_LSB +: NCH];
    clr_ck      = {NCH{wr_clear}} & bus_wdata[ST_CK_LSB +: NCH];
    clr_hi      = {NCH{wr_wdclr}} & bus_wdata[WD_HI_LSB +: NCH];
    clr_lo      = {NCH{wr_wdclr}} & bus_wdata[WD_LO_LSB +: NCH];
  end

  // conversion groups
  logic             inj_eoc, inj_ovr, reg_eoc, reg_ovr;
  logic [RES_W-1:0] inj_res, reg_res;

  cevt_grp_flags #(.RES_W(RES_W)) u_inj (
    .clk(clk), .rst_n(rst_s_n), .done(inj_done), .data(inj_data),
    .rd_clr(rd_inj), .ovr_clr(clr_inj_ovr),
    .eoc(inj_eoc), .ovr(inj_ovr), .result(inj_res)
  );

  cevt_grp_flags #(.RES_W(RES_W)) u_reg (
    .clk(clk), .rst_n(rst_s_n), .done(reg_done), .data(reg_data),
    .rd_clr(rd_reg), .ovr_clr(clr_reg_ovr),
    .eoc(reg_eoc), .ovr(reg_ovr), .result(reg_res)
  );

  // per-channel flag banks
  logic [NCH-1:0] hi_f, lo_f, sc_f, ck_f;

  cevt_chan_flags #(.N(NCH)) u_hi (
    .clk(clk), .rst_n(rst_s_n), .evt(wd_hi_evt), .det_en(ALL_ON),
    .clr(clr_hi), .flags(hi_f)
  );
  cevt_chan_flags #(.N(NCH)) u_lo (
    .clk(clk), .rst_n(rst_s_n), .evt(wd_lo_evt), .det_en(ALL_ON),
    .clr(clr_lo), .flags(lo_f)
  );
  cevt_chan_flags #(.N(NCH)) u_sc (
    .clk(clk), .rst_n(rst_s_n), .evt(sc_evt), .det_en(sc_det_en),
    .clr(clr_sc), .flags(sc_f)
  );
  cevt_chan_flags #(.N(NCH)) u_ck (
    .clk(clk), .rst_n(rst_s_n), .evt(ck_evt), .det_en(ck_det_en),
    .clr(clr_ck), .flags(ck_f)
  );

  // source vector and interrupt
  src_t src;
  logic wd_sum;

  always_comb begin
    wd_sum      = (|hi_f) | (|lo_f);
    src.inj_eoc = inj_eoc;
    src.reg_eoc = reg_eoc;
    src.inj_ovr = inj_ovr;
    src.reg_ovr = reg_ovr;
    src.wd      = wd_sum;
    src.sc      = |sc_f;
    src.ck      = |ck_f;
  end

  cevt_irq_out #(.NS(N_SRC)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .src(src), .en(en_q), .irq(irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (a)
      A_STATUS: begin
        bus_rdata[ST_INJ_EOC]          = inj_eoc;
        bus_rdata[ST_REG_EOC]          = reg_eoc;
        bus_rdata[ST_INJ_OVR]          = inj_ovr;
        bus_rdata[ST_REG_OVR]          = reg_ovr;
        bus_rdata[ST_WD_SUM]           = wd_sum;
        bus_rdata[ST_SC_LSB +: NCH]    = sc_f;
        bus_rdata[ST_CK_LSB +: NCH]    = ck_f;
      end
      A_ENABLE: bus_rdata[N_SRC-1:0]   = en_q;
      A_WDSTAT: begin
        bus_rdata[WD_HI_LSB +: NCH]    = hi_f;
        bus_rdata[WD_LO_LSB +: NCH]    = lo_f;
      end
      A_INJRES: bus_rdata[RES_W-1:0]   = inj_res;
      A_REGRES: bus_rdata[RES_W-1:0]   = reg_res;
      default:  bus_rdata              = '0;
    endcase
  end

  assert_irq_off_when_masked_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_q == '0) |=> !irq);
  assert_summary_tracks_bits_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((hi_f == '0) && (lo_f == '0) && (wd_hi_evt == '0) && (wd_lo_evt == '0)) |=> !src.wd);
endmodule

// File: tb/sim_cevt_irq_unit.sv
module sim_cevt_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        inj_done = 1'b0;
  logic [23:0] inj_data = '0;
  logic        reg_done = 1'b0;
  logic [23:0] reg_data = '0;
  logic [3:0]  wd_hi_evt = '0, wd_lo_evt = '0, sc_evt = '0, sc_det_en = '0;
  logic [3:0]  ck_evt = '0, ck_det_en = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  localparam logic [2:0] STAT = 3'd0, ENA = 3'd1, CLR = 3'd2, WDS = 3'd3,
                         WDC = 3'd4, INJR = 3'd5, REGR = 3'd6;

  // hi, lo, sc, sc_en, ck, ck_en, expected sc, expected ck, expected summary
  localparam logic [35:0] TBL [6] = '{
    {4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1},
    {4'h0, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1},
    {4'h0, 4'h0, 4'hF, 4'h5, 4'h0, 4'h0, 4'h5, 4'h0, 4'h0},
    {4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h2, 4'h0, 4'h2, 4'h0},
    {4'h0, 4'h0, 4'h6, 4'h0, 4'h9, 4'h0, 4'h0, 4'h0, 4'h0},
    {4'hA, 4'h5, 4'h8, 4'hC, 4'h4, 4'h6, 4'h8, 4'h4, 4'h1}
  };

  cevt_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .inj_done(inj_done), .inj_data(inj_data), .reg_done(reg_done),
    .reg_data(reg_data), .wd_hi_evt(wd_hi_evt), .wd_lo_evt(wd_lo_evt),
    .sc_evt(sc_evt), .sc_det_en(sc_det_en), .ck_evt(ck_evt),
    .ck_det_en(ck_det_en), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ad; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] ad, input logic [31:0] exp);
    logic [31:0] v;
    rd(ad, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_inj(input logic [23:0] d);
    @(negedge clk); inj_done = 1'b1; inj_data = d;
    @(negedge clk); inj_done = 1'b0;
  endtask

  task automatic pulse_reg(input logic [23:0] d);
    @(negedge clk); reg_done = 1'b1; reg_data = d;
    @(negedge clk); reg_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 irq", {31'b0, irq}, 32'h0);
    rdchk("R12 status", STAT, 32'h0);
    rdchk("R12 enable", ENA, 32'h0);
    rdchk("R12 wd status", WDS, 32'h0);
    rdchk("R12 result", REGR, 32'h0);

    // R1 / R2
    pulse_reg(24'h123456);
    rdchk("R1 reg complete", STAT, 32'h2);
    rdchk("R1 reg result", REGR, 32'h0012_3456);
    rdchk("R2 cleared by read", STAT, 32'h0);

    // R3 / R4
    pulse_inj(24'h0000AA);
    pulse_inj(24'h0000BB);
    rdchk("R3 inj overrun", STAT, 32'h5);
    wr(CLR, 32'h0);
    rdchk("R4 zero write keeps", STAT, 32'h5);
    wr(CLR, 32'h4);
    rdchk("R4 one clears", STAT, 32'h1);
    rdchk("R1 inj result", INJR, 32'h0000_00BB);
    rdchk("R2 inj cleared", STAT, 32'h0);
    pulse_inj(24'h0000CC);
    rdchk("R3 no overrun after read", STAT, 32'h1);
    rdchk("R1 inj result 2", INJR, 32'h0000_00CC);

    // R5 read and new result in one cycle
    pulse_reg(24'h000111);
    @(negedge clk);
    reg_done = 1'b1; reg_data = 24'h000222; bus_addr = REGR; bus_rd = 1'b1;
    #1 chk("R5 old word read", bus_rdata, 32'h0000_0111);
    @(negedge clk);
    reg_done = 1'b0; bus_rd = 1'b0;
    rdchk("R5 complete kept no overrun", STAT, 32'h2);
    rdchk("R5 new word", REGR, 32'h0000_0222);
    rdchk("R5 cleared", STAT, 32'h0);

    // table walk: R6 R7 R8 R9
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wd_hi_evt = TBL[k][35:32]; wd_lo_evt = TBL[k][31:28];
      sc_evt = TBL[k][27:24]; sc_det_en = TBL[k][23:20];
      ck_evt = TBL[k][19:16]; ck_det_en = TBL[k][15:12];
      @(negedge clk);
      wd_hi_evt = '0; wd_lo_evt = '0; sc_evt = '0; sc_det_en = '0;
      ck_evt = '0; ck_det_en = '0;
      rdchk("R7/R8/R9 status vector", STAT,
            (32'(TBL[k][7:4]) << 16) | (32'(TBL[k][11:8]) << 8) | (32'(TBL[k][0]) << 4));
      rdchk("R6 wd status vector", WDS,
            (32'(TBL[k][31:28]) << 8) | 32'(TBL[k][35:32]));
      wr(CLR, 32'hFFFF_FFFF);
      wr(WDC, 32'hFFFF_FFFF);
      rdchk("R8/R9 cleared", STAT, 32'h0);
      rdchk("R6 cleared", WDS, 32'h0);
    end

    // R6 individual clear, R7 summary
    @(negedge clk); wd_hi_evt = 4'hF; wd_lo_evt = 4'hF;
    @(negedge clk); wd_hi_evt = '0; wd_lo_evt = '0;
    wr(WDC, 32'h0000_0102);
    rdchk("R6 per bit clear", WDS, 32'h0000_0E0D);
    rdchk("R7 summary set", STAT, 32'h10);
    wr(WDC, 32'h0000_0F0F);
    rdchk("R7 summary clear", STAT, 32'h0);

    // R10 set beats clear
    @(negedge clk);
    ck_evt = 4'h4; ck_det_en = 4'hF;
    bus_addr = CLR; bus_wdata = 32'h0004_0000; bus_wr = 1'b1;
    @(negedge clk);
    ck_evt = '0; ck_det_en = '0; bus_wr = 1'b0;
    rdchk("R10 clock absence kept", STAT, 32'h0004_0000);
    @(negedge clk);
    wd_hi_evt = 4'h2; bus_addr = WDC; bus_wdata = 32'h2; bus_wr = 1'b1;
    @(negedge clk);
    wd_hi_evt = '0; bus_wr = 1'b0;
    rdchk("R10 wd high kept", WDS, 32'h2);
    wr(CLR, 32'hFFFF_FFFF);
    wr(WDC, 32'hFFFF_FFFF);
    rdchk("R10 cleanup", STAT, 32'h0);

    // R11 interrupt timing and masking
    wr(ENA, 32'h2);
    chk("R11 idle", {31'b0, irq}, 32'h0);
    pulse_reg(24'h000333);
    chk("R11 one cycle lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 raised", {31'b0, irq}, 32'h1);
    wr(ENA, 32'h0);
    chk("R11 lag on mask", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R11 masked flag silent", {31'b0, irq}, 32'h0);
    rdchk("R11 flag still set", STAT, 32'h2);
    rdchk("R11 drain result", REGR, 32'h0000_0333);
    wr(ENA, 32'h20);
    @(negedge clk); sc_evt = 4'h1; sc_det_en = 4'h1;
    @(negedge clk); sc_evt = '0; sc_det_en = '0;
    @(negedge clk);
    chk("R11 short-circuit source", {31'b0, irq}, 32'h1);
    wr(CLR, 32'h0000_0100);
    @(negedge clk);
    chk("R11 drops after clear", {31'b0, irq}, 32'h0);

    done_run = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule